// File: doc/BRIEF.md
# JTAG Byte Shifter with Direct Pin Control

This block is a JTAG master engine. A host hands it one command at a time over a valid/ready handshake. It drives the four JTAG lines and an active-low output-enable indicator. Two kinds of command exist.

Pin commands take a state byte and place chosen bits straight onto TCK, TMS, TDI and the indicator. The read variant then returns a status byte that carries the sampled TDO.

Shift commands clock one data byte out on TDI, least significant bit first, over eight TCK pulses. The capturing variant also collects eight TDO samples into a result byte. TCK timing comes from the system clock through a programmable half-period divider. The engine latches the divider value when it accepts a shift.

Completion is signalled by a one-cycle done pulse. The result byte then stays on its port until another result replaces it.

Top module: `jtag_byte_engine`

## Requirements
- R1: While reset is held and right after it, TCK, TMS and TDI are low, the indicator output is high (off), ready is high, done is low and the result byte is zero.
- R2: The operation code is carried in two bits: 00 is pin set, 01 is pin read, 10 is shift, 11 is shift with capture. A pin set drives TCK from data bit 0, TMS from bit 1 and TDI from bit 4, all from the clock edge that accepts it. Done pulses on that same edge.
- R3: Data bit 5 of a pin command drives the indicator low when set and high when clear. The indicator never changes while the engine is busy.
- R4: A pin read applies the pins on its accepting edge. On the next edge it raises done and presents a result whose bit 0 is TDO, sampled with the new pins already applied, whose bit 1 is 1, and whose other bits are 0.
- R5: A shift sends the eight data bits on TDI, bit 0 first. The accepting edge forces TCK low. Each bit then takes one setup edge that updates TDI while TCK is low, H clocks of TCK low, H clocks of TCK high, and a falling edge. TCK ends low, and TDI changes only while TCK is and was low.
- R6: The half-period H equals the divider input, and a value of 0 counts as 1. H is latched when a shift is accepted; changing the divider input during a shift has no effect on that shift.
- R7: In shift with capture, TDO is sampled at each bit's setup edge, before TDI changes and before TCK rises. The result shifts right per sample with the new sample entering at bit 7, so the first sample ends in bit 0. The result is presented with done on the final falling edge.
- R8: In a plain shift, TDO is ignored: done pulses on the final falling edge and the result byte keeps its previous value.
- R9: Ready is high only when the engine is idle. Commands offered while the engine is busy are ignored. Done lasts one cycle unless another command completes on the next edge, and the result byte changes only on a done edge.
- R10: During a shift, TMS keeps the value set by the most recent pin command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | TCK half-period in system clocks (0 treated as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | Operation code |
| cmd_data | input | DATA_W | State byte or data byte |
| rsp_done | output | 1 | Completion pulse |
| rsp_data | output | DATA_W | Result byte, held until replaced |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data towards the target |
| jtag_tdo | input | 1 | Test data from the target |
| oe_ind_n | output | 1 | Output-enable indicator, active low |

## Verification
The bench builds the engine with DATA_W = 8 and DIV_W = 4. A four-bit divider lets the run reach both extremes of the half-period: the zero value that must act as one, and the largest value, 15, within a few hundred cycles per byte. Small and medium values in between show that the low and high phases scale with H. The TDO model advances on each falling TCK. This shows that each capture sample is taken before the bit's rising edge.

// File: rtl/jbe_pkg.sv
package jbe_pkg;

    typedef enum logic [1:0] {
        OP_PIN_SET   = 2'b00,
        OP_PIN_READ  = 2'b01,
        OP_SHIFT     = 2'b10,
        OP_SHIFT_CAP = 2'b11
    } jbe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAD,
        ST_START,
        ST_LOW,
        ST_HIGH
    } jbe_state_e;

    // Positions inside a pin-command state byte
    localparam int PIN_TCK = 0;
    localparam int PIN_TMS = 1;
    localparam int PIN_TDI = 4;
    localparam int PIN_OE  = 5;

    // Positions inside a pin-read status byte
    localparam int STS_TDO = 0;
    localparam int STS_ONE = 1;

endpackage

// File: rtl/jbe_halftimer.sv
module jbe_halftimer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/jbe_shifter.sv
module jbe_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sample,
    input  logic              sample_bit,
    input  logic              advance,
    output logic              out_bit,
    output logic [DATA_W-1:0] cap_byte
);
    typedef struct packed {
        logic [DATA_W-1:0] outr;
        logic [DATA_W-1:0] cap;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)
            sh_d.outr = load_data;
        else if (advance)
            sh_d.outr = {1'b0, sh_q.outr[DATA_W-1:1]};
        if (sample)
            sh_d.cap = {sample_bit, sh_q.cap[DATA_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign out_bit  = sh_q.outr[0];
    assign cap_byte = sh_q.cap;
endmodule

// File: rtl/jtag_byte_engine.sv
module jtag_byte_engine
    import jbe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              jtag_tck,
    output logic              jtag_tms,
    output logic              jtag_tdi,
    input  logic              jtag_tdo,
    output logic              oe_ind_n
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        jbe_state_e        st;
        logic              tck;
        logic              tms;
        logic              tdi;
        logic              oe_n;
        logic              capen;
        logic [CNT_W-1:0]  bitn;
        logic [DIV_W-1:0]  half;
        logic              done;
        logic [DATA_W-1:0] rsp;
    } eng_t;

    eng_t d, q;

    logic              tmr_load;
    logic              tmr_exp;
    logic              sh_load;
    logic              sh_sample;
    logic              sh_adv;
    logic              sh_bit;
    logic [DATA_W-1:0] sh_cap;

    jbe_halftimer #(.W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (q.half - 1'b1),
        .expired  (tmr_exp)
    );

    jbe_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .load_data  (cmd_data),
        .sample     (sh_sample),
        .sample_bit (jtag_tdo),
        .advance    (sh_adv),
        .out_bit    (sh_bit),
        .cap_byte   (sh_cap)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        tmr_load  = 1'b0;
        sh_load   = 1'b0;
        sh_sample = 1'b0;
        sh_adv    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (jbe_op_e'(cmd_op))
                        OP_PIN_SET, OP_PIN_READ: begin
                            d.tck  = cmd_data[PIN_TCK];
                            d.tms  = cmd_data[PIN_TMS];
                            d.tdi  = cmd_data[PIN_TDI];
                            d.oe_n = ~cmd_data[PIN_OE];
                            if (jbe_op_e'(cmd_op) == OP_PIN_SET) d.done = 1'b1;
                            else                                 d.st   = ST_PREAD;
                        end
                        default: begin
                            sh_load = 1'b1;
                            d.tck   = 1'b0;
                            d.bitn  = '0;
                            d.capen = (jbe_op_e'(cmd_op) == OP_SHIFT_CAP);
                            d.half  = (half_div == '0) ? DIV_W'(1) : half_div;
                            d.st    = ST_START;
                        end
                    endcase
                end
            end
            ST_PREAD: begin
                d.rsp          = '0;
                d.rsp[STS_ONE] = 1'b1;
                d.rsp[STS_TDO] = jtag_tdo;
                d.done         = 1'b1;
                d.st           = ST_IDLE;
            end
            ST_START: begin
                sh_sample = q.capen;
                d.tdi     = sh_bit;
                tmr_load  = 1'b1;
                d.st      = ST_LOW;
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    d.tck    = 1'b1;
                    tmr_load = 1'b1;
                    d.st     = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_exp) begin
                    d.tck  = 1'b0;
                    sh_adv = 1'b1;
                    if (q.bitn == LAST_BIT) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                        if (q.capen) d.rsp = sh_cap;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                        d.st   = ST_START;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.oe_n  <= 1'b1;
            q.half  <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == ST_IDLE);
    assign rsp_done  = q.done;
    assign rsp_data  = q.rsp;
    assign jtag_tck  = q.tck;
    assign jtag_tms  = q.tms;
    assign jtag_tdi  = q.tdi;
    assign oe_ind_n  = q.oe_n;
endmodule

// File: rtl/jbe_checker.sv
module jbe_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_data,
    input logic              jtag_tck,
    input logic              jtag_tms,
    input logic              jtag_tdi,
    input logic              oe_ind_n
);
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> cmd_ready) else $error("done while busy"); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> $stable(rsp_data)) else $error("result moved without done"); // R9

    AST_TCK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(jtag_tck) && $past(cmd_ready)) |-> $past(cmd_valid)) else $error("tck moved while idle"); // R9

    AST_TMS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cmd_ready) |-> $stable(jtag_tms)) else $error("tms moved while busy"); // R10

    AST_TDI_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cmd_ready) && !$stable(jtag_tdi)) |-> (!jtag_tck && !$past(jtag_tck))) else $error("tdi moved with tck high"); // R5

    AST_OE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cmd_ready) |-> $stable(oe_ind_n)) else $error("indicator moved while busy"); // R3
endmodule

bind jtag_byte_engine jbe_checker #(.DATA_W(DATA_W)) u_jbe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_done  (rsp_done),
    .rsp_data  (rsp_data),
    .jtag_tck  (jtag_tck),
    .jtag_tms  (jtag_tms),
    .jtag_tdi  (jtag_tdi),
    .oe_ind_n  (oe_ind_n)
);

// File: tb/jtag_byte_engine_bench.sv
module jtag_byte_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DIVW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DIVW-1:0] half_div = '0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [1:0]      cmd_op = 2'b00;
    logic [DW-1:0]   cmd_data = '0;
    logic            rsp_done;
    logic [DW-1:0]   rsp_data;
    logic            jtag_tck, jtag_tms, jtag_tdi, jtag_tdo, oe_ind_n;

    // TDO source: loopback of the pins, or a byte stepped on each falling TCK
    logic            tdo_mode = 1'b0;
    logic [7:0]      tdo_src = '0;
    int              falls = 0;
    int              fall_base = 0;

    always @(negedge jtag_tck) falls <= falls + 1;
    assign jtag_tdo = tdo_mode ? tdo_src[3'((falls - fall_base) & 7)] : (jtag_tdi ^ jtag_tms);

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_byte_engine #(.DATA_W(DW), .DIV_W(DIVW)) u_jtag_byte_engine (
        .clk(clk), .rst_n(rst_n), .half_div(half_div),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_done(rsp_done), .rsp_data(rsp_data),
        .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi),
        .jtag_tdo(jtag_tdo), .oe_ind_n(oe_ind_n)
    );

    // Reference state
    logic          e_tck = 0, e_tms = 0, e_tdi = 0, e_oe = 1, e_rdy = 1, e_done = 0;
    logic [DW-1:0] e_rsp = '0;
    int n_chk = 0, n_fail = 0;
    bit reported = 0;

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tp, string ttms, string tr);
        chk(tp,   "tck",   DW'(jtag_tck), DW'(e_tck));
        chk(tp,   "tdi",   DW'(jtag_tdi), DW'(e_tdi));
        chk(ttms, "tms",   DW'(jtag_tms), DW'(e_tms));
        chk("R3", "oe_n",  DW'(oe_ind_n), DW'(e_oe));
        chk("R9", "ready", DW'(cmd_ready), DW'(e_rdy));
        chk("R9", "done",  DW'(rsp_done), DW'(e_done));
        chk(tr,   "rsp",   rsp_data, e_rsp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            e_done = 0; e_rdy = 1;
            compare("R9", "R9", "R9");
        end
    endtask

    task automatic pin_set(logic [7:0] v);
        cmd_valid = 1; cmd_op = 2'b00; cmd_data = v;
        @(negedge clk);
        cmd_valid = 0;
        e_tck = v[0]; e_tms = v[1]; e_tdi = v[4]; e_oe = ~v[5];
        e_done = 1; e_rdy = 1;
        compare("R2", "R2", "R9");
        idle(1);
    endtask

    task automatic pin_read(logic [7:0] v);
        tdo_mode = 0;
        cmd_valid = 1; cmd_op = 2'b01; cmd_data = v;
        @(negedge clk);
        cmd_valid = 0;
        e_tck = v[0]; e_tms = v[1]; e_tdi = v[4]; e_oe = ~v[5];
        e_done = 0; e_rdy = 0;
        compare("R4", "R4", "R4");
        @(negedge clk);
        e_rsp = {6'b0, 1'b1, e_tdi ^ e_tms};
        e_done = 1; e_rdy = 1;
        compare("R4", "R4", "R4");
        idle(1);
    endtask

    // One shift byte; poke keeps a junk command and a changed divider on the inputs while busy
    task automatic run_shift(bit cap, logic [7:0] v, int div, logic [7:0] src, bit poke);
        int h;
        string tr;
        h  = (div == 0) ? 1 : div;
        tr = cap ? "R7" : "R8";
        half_div = DIVW'(div);
        cmd_valid = 1; cmd_op = cap ? 2'b11 : 2'b10; cmd_data = v;
        @(negedge clk);
        tdo_mode = 1; tdo_src = src; fall_base = falls;
        cmd_valid = poke;
        if (poke) begin cmd_op = 2'b00; cmd_data = 8'hFF; half_div = ~DIVW'(div); end
        e_tck = 0; e_rdy = 0; e_done = 0;
        compare("R5", "R10", tr);
        for (int b = 0; b < 8; b++) begin
            if (b > 0) begin
                @(negedge clk);
                e_tck = 0;
                compare("R5", "R10", tr);
            end
            e_tdi = v[b];
            for (int i = 0; i < h; i++) begin
                @(negedge clk);
                compare((div == 0 || poke) ? "R6" : "R5", "R10", tr);
            end
            e_tck = 1;
            for (int i = 0; i < h; i++) begin
                @(negedge clk);
                compare((div == 0 || poke) ? "R6" : "R5", "R10", tr);
            end
        end
        cmd_valid = 0;
        half_div = DIVW'(div);
        @(negedge clk);
        e_tck = 0; e_rdy = 1; e_done = 1;
        if (cap) e_rsp = src;
        compare("R5", "R10", tr);
        idle(2);
        tdo_mode = 0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired before the run ended");
        report();
    end

    initial begin
        // R1: reset values, during and just after reset
        repeat (3) @(negedge clk);
        compare("R1", "R1", "R1");
        rst_n = 1;
        @(negedge clk);
        compare("R1", "R1", "R1");
        idle(2);

        // R2, R3: pin map and active-low indicator
        pin_set(8'h13);
        pin_set(8'h20);
        pin_set(8'h00);
        pin_set(8'h32);

        // R4: status byte from TDO after new pins are applied
        pin_read(8'h12);
        pin_read(8'h02);
        pin_read(8'h20);

        // leave TCK high and TMS set before a shift: R5 forces TCK low, R10 keeps TMS
        pin_set(8'h03);
        // R5, R8: plain shift, TDO toggling but ignored
        run_shift(1'b0, 8'hA5, 1, 8'h3C, 1'b0);
        // R7: capture with H = 2
        run_shift(1'b1, 8'h5A, 2, 8'hC3, 1'b0);
        // R6: divider zero acts as one
        run_shift(1'b1, 8'h81, 0, 8'h96, 1'b0);
        // R9, R6: commands and divider changes while busy are ignored
        pin_set(8'h00);
        run_shift(1'b0, 8'h3C, 3, 8'hFF, 1'b1);
        // R6, R7: largest half-period
        run_shift(1'b1, 8'hFF, 15, 8'h01, 1'b0);
        // R4 after shifts: result replaced by status
        pin_read(8'h10);
        idle(3);
        report();
    end
endmodule